// File: doc/BRIEF.md
# BCD Calendar Clock with Memory-Mapped Registers

This block keeps wall-clock time and calendar date in packed BCD and exposes them as eight byte-wide registers at the highest eight addresses of a byte-addressed map. A one-cycle pulse on the tick input marks each elapsed second. The block advances seconds and carries through minutes, hours, date, day of week, month and a two-digit year. Date rollover follows month lengths, with a leap February in every year whose two-digit value is a multiple of four.

Software reads and writes the registers through a simple strobe port. Three control bits govern access. A hold bit in the control register suspends counting so that a full time can be loaded without tearing. A freeze bit makes reads of the time registers return a snapshot while the clock keeps running underneath. A stop bit in the seconds register halts timekeeping altogether. The control register also stores a sign bit and a five-bit magnitude for use by an external trimming circuit. A frequency-test bit in the day register is stored and read back.

Top module: `bcd_calendar_rtc`

## Requirements
- R1: A register access hits when every address bit above bit 2 is 1. The low three bits select the register: 0 control, 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 date, 6 month, 7 year. A read outside this window returns 0x00, and a write outside it changes nothing.
- R2: After reset the registers read as follows: control 0x00, seconds 0x00, minutes 0x00, hours 0x00, day 0x01, date 0x01, month 0x01, year 0x00.
- R3: Each tick pulse that is not blocked advances seconds by one in BCD. Seconds wrap 59 to 00 and carry into minutes. Minutes wrap 59 to 00 and carry into hours. Hours wrap 23 to 00 and carry into the date.
- R4: A date carry wraps the date to 01 after the last day of the month. April, June, September and November have 30 days, February has 28 days, or 29 when the year value is divisible by 4 (00 included), and the other months have 31. Month 12 wraps to 01 and carries into the year, and year 99 wraps to 00.
- R5: The day of week advances by one on every date carry and wraps from 07 to 01.
- R6: Seconds bit 7 is the stop bit. While it is 1, ticks have no effect on the time. It reads back as written.
- R7: Control bit 7 is the hold bit. While it is 1, ticks are ignored, but register writes still load the time. After it is cleared, counting resumes from the loaded values.
- R8: Control bit 6 is the freeze bit. While it is 1, reads of the seven time registers return the time as it stood in the cycle the bit was set, while counting continues. After the bit is cleared, reads show the live time.
- R9: Unused bits read 0. Minutes reads bits 6:0, hours bits 5:0, date bits 5:0, month bits 4:0, and day reads bits 2:0 plus the frequency-test bit in bit 6. Year and control keep all eight bits; control bit 5 is the trim sign and bits 4:0 the trim magnitude.
- R10: Read data updates on the clock edge that samples a read strobe (sel_i=1, we_i=0) and holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-cycle pulse per elapsed second |
| sel_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read when sel_i is 1 |
| addr_i | input | ADDR_W (13) | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |

## Verification
The bench uses the default 13-bit address, so the register window lies at 0x1FF8 to 0x1FFF and the address 0x0FF9 serves as an alias that must miss. It sweeps every second of the first hour after reset. It then walks every day from 1 January of year 98 through 31 December of year 02, forcing each day to 23:59:59 and ticking once. This covers every month length, two leap Februaries (year 00 and the shifted-digit case checked separately), the December and century wraps and the day-of-week cycle, all against a calendar computed arithmetically in the bench.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] min;
    logic [5:0] hour;
    logic [2:0] dow;
    logic [5:0] date;
    logic [4:0] month;
    logic [7:0] year;
  } rtc_time_t;

  typedef enum logic [2:0] {
    OFS_CTRL  = 3'd0,
    OFS_SEC   = 3'd1,
    OFS_MIN   = 3'd2,
    OFS_HOUR  = 3'd3,
    OFS_DOW   = 3'd4,
    OFS_DATE  = 3'd5,
    OFS_MONTH = 3'd6,
    OFS_YEAR  = 3'd7
  } rtc_ofs_e;

  localparam int unsigned CTL_HOLD_BIT   = 7;
  localparam int unsigned CTL_FREEZE_BIT = 6;

  // Increment a two-digit packed BCD value (no wrap at 99 here).
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] >= 4'd9) begin
      r = {v[7:4] + 4'd1, 4'd0};
    end else begin
      r = {v[7:4], v[3:0] + 4'd1};
    end
    return r;
  endfunction

endpackage

// File: rtl/rtc_month_len.sv
module rtc_month_len
  import rtc_pkg::*;
(
  input  logic [4:0] month_i,
  input  logic [7:0] year_i,
  output logic [5:0] last_day_o
);

  logic [1:0] mod4;
  logic       leap;

  // (10*t + u) mod 4 == (2*t + u) mod 4
  always_comb begin
    mod4 = {year_i[4], 1'b0} + year_i[1:0];
    leap = (mod4 == 2'd0);
  end

  always_comb begin
    unique case (month_i)
      5'h02:                       last_day_o = leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11:  last_day_o = 6'h30;
      default:                     last_day_o = 6'h31;
    endcase
  end

endmodule

// File: rtl/rtc_time_step.sv
module rtc_time_step
  import rtc_pkg::*;
(
  input  rtc_time_t cur_i,
  output rtc_time_t nxt_o
);

  logic [5:0] last_day;
  logic       sec_wrap, min_wrap, hour_wrap, date_wrap, month_wrap;
  logic       c_min, c_hour, c_day, c_month, c_year;
  logic [7:0] sec_inc, min_inc, hour_inc, date_inc, month_inc, year_inc;

  rtc_month_len u_len (
    .month_i    (cur_i.month),
    .year_i     (cur_i.year),
    .last_day_o (last_day)
  );

  always_comb begin
    sec_inc   = bcd_inc({1'b0, cur_i.sec});
    min_inc   = bcd_inc({1'b0, cur_i.min});
    hour_inc  = bcd_inc({2'b0, cur_i.hour});
    date_inc  = bcd_inc({2'b0, cur_i.date});
    month_inc = bcd_inc({3'b0, cur_i.month});
    year_inc  = bcd_inc(cur_i.year);

    sec_wrap   = (cur_i.sec   >= 7'h59);
    min_wrap   = (cur_i.min   >= 7'h59);
    hour_wrap  = (cur_i.hour  >= 6'h23);
    date_wrap  = (cur_i.date  >= last_day);
    month_wrap = (cur_i.month >= 5'h12);

    c_min   = sec_wrap;
    c_hour  = c_min  & min_wrap;
    c_day   = c_hour & hour_wrap;
    c_month = c_day  & date_wrap;
    c_year  = c_month & month_wrap;
  end

  always_comb begin
    nxt_o = cur_i;
    nxt_o.sec = sec_wrap ? 7'h00 : sec_inc[6:0];
    if (c_min) begin
      nxt_o.min = min_wrap ? 7'h00 : min_inc[6:0];
    end
    if (c_hour) begin
      nxt_o.hour = hour_wrap ? 6'h00 : hour_inc[5:0];
    end
    if (c_day) begin
      nxt_o.date = date_wrap ? 6'h01 : date_inc[5:0];
      nxt_o.dow  = (cur_i.dow >= 3'd7) ? 3'd1 : cur_i.dow + 3'd1;
    end
    if (c_month) begin
      nxt_o.month = month_wrap ? 5'h01 : month_inc[4:0];
    end
    if (c_year) begin
      nxt_o.year = (cur_i.year >= 8'h99) ? 8'h00 : year_inc;
    end
  end

endmodule

// File: rtl/rtc_read_mux.sv
module rtc_read_mux
  import rtc_pkg::*;
(
  input  logic [2:0] ofs_i,
  input  rtc_time_t  view_i,
  input  logic       stop_i,
  input  logic       ftest_i,
  input  logic [7:0] ctl_i,
  output logic [7:0] byte_o
);

  always_comb begin
    unique case (rtc_ofs_e'(ofs_i))
      OFS_CTRL:  byte_o = ctl_i;
      OFS_SEC:   byte_o = {stop_i, view_i.sec};
      OFS_MIN:   byte_o = {1'b0, view_i.min};
      OFS_HOUR:  byte_o = {2'b0, view_i.hour};
      OFS_DOW:   byte_o = {1'b0, ftest_i, 3'b0, view_i.dow};
      OFS_DATE:  byte_o = {2'b0, view_i.date};
      OFS_MONTH: byte_o = {3'b0, view_i.month};
      OFS_YEAR:  byte_o = view_i.year;
      default:   byte_o = 8'h00;
    endcase
  end

endmodule

// File: rtl/bcd_calendar_rtc.sv
module bcd_calendar_rtc
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);

  localparam int unsigned OFS_W = 3;
  localparam int unsigned HI_W  = ADDR_W - OFS_W;

  // Reset synchronizer: asserts asynchronously, releases on the clock.
  logic rst_meta_q, rst_n_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_n_q    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_q    <= rst_meta_q;
    end
  end

  rtc_time_t  time_q, time_d, time_adv;
  rtc_time_t  snap_q, snap_d, view;
  logic       stop_q, stop_d;
  logic       ftest_q, ftest_d;
  logic [7:0] ctl_q, ctl_d;
  logic [7:0] rdata_q, rdata_d;
  logic [7:0] rd_byte;

  logic [OFS_W-1:0] ofs;
  logic [HI_W-1:0]  addr_hi;
  logic             win_hit, wr_hit, rd_hit, wr_time, count_en;

  always_comb begin
    ofs      = addr_i[OFS_W-1:0];
    addr_hi  = addr_i[ADDR_W-1:OFS_W];
    win_hit  = &addr_hi;
    wr_hit   = sel_i & we_i & win_hit;
    rd_hit   = sel_i & ~we_i;
    wr_time  = wr_hit & (ofs != OFS_CTRL);
    // A load of a time register wins over a tick in the same cycle.
    count_en = tick_i & ~stop_q & ~ctl_q[CTL_HOLD_BIT] & ~wr_time;
  end

  rtc_time_step u_step (
    .cur_i (time_q),
    .nxt_o (time_adv)
  );

  // Time, stop, frequency-test and control next state
  always_comb begin
    time_d  = count_en ? time_adv : time_q;
    stop_d  = stop_q;
    ftest_d = ftest_q;
    ctl_d   = ctl_q;
    if (wr_hit) begin
      unique case (rtc_ofs_e'(ofs))
        OFS_CTRL:  ctl_d = wdata_i;
        OFS_SEC: begin
          stop_d      = wdata_i[7];
          time_d.sec  = wdata_i[6:0];
        end
        OFS_MIN:   time_d.min   = wdata_i[6:0];
        OFS_HOUR:  time_d.hour  = wdata_i[5:0];
        OFS_DOW: begin
          ftest_d    = wdata_i[6];
          time_d.dow = wdata_i[2:0];
        end
        OFS_DATE:  time_d.date  = wdata_i[5:0];
        OFS_MONTH: time_d.month = wdata_i[4:0];
        OFS_YEAR:  time_d.year  = wdata_i;
        default:   ctl_d = ctl_q;
      endcase
    end
  end

  // Snapshot tracks the live time until the freeze bit is set.
  always_comb begin
    snap_d = ctl_q[CTL_FREEZE_BIT] ? snap_q : time_q;
    view   = ctl_q[CTL_FREEZE_BIT] ? snap_q : time_q;
  end

  rtc_read_mux u_rmux (
    .ofs_i   (ofs),
    .view_i  (view),
    .stop_i  (stop_q),
    .ftest_i (ftest_q),
    .ctl_i   (ctl_q),
    .byte_o  (rd_byte)
  );

  always_comb begin
    rdata_d = rdata_q;
    if (rd_hit) begin
      rdata_d = win_hit ? rd_byte : 8'h00;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_q) begin
    if (!rst_n_q) begin
      time_q.sec   <= 7'h00;
      time_q.min   <= 7'h00;
      time_q.hour  <= 6'h00;
      time_q.dow   <= 3'd1;
      time_q.date  <= 6'h01;
      time_q.month <= 5'h01;
      time_q.year  <= 8'h00;
      snap_q       <= '0;
      stop_q       <= 1'b0;
      ftest_q      <= 1'b0;
      ctl_q        <= 8'h00;
      rdata_q      <= 8'h00;
    end else begin
      time_q  <= time_d;
      snap_q  <= snap_d;
      stop_q  <= stop_d;
      ftest_q <= ftest_d;
      ctl_q   <= ctl_d;
      rdata_q <= rdata_d;
    end
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/rtc_checks.sv
module rtc_checks
  import rtc_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       sel_i,
  input logic       we_i,
  input rtc_time_t  time_q,
  input rtc_time_t  snap_q,
  input logic       stop_q,
  input logic [7:0] ctl_q,
  input logic [7:0] rdata_o
);

  logic any_wr;
  assign any_wr = sel_i & we_i;

  a_r3_tick_moves_sec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !stop_q && !ctl_q[7] && !any_wr) |=> (time_q.sec != $past(time_q.sec)));

  a_r3_min_needs_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!any_wr && time_q.sec < 7'h59) |=> $stable(time_q.min));

  a_r5_dow_with_date: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!any_wr) |=> ((time_q.date != $past(time_q.date)) == (time_q.dow != $past(time_q.dow))));

  a_r6_stop_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_q && !any_wr) |=> $stable(time_q));

  a_r7_hold_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_q[7] && !any_wr) |=> $stable(time_q));

  a_r8_snapshot_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_q[6] |=> $stable(snap_q));

  a_r10_rdata_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && !we_i) |=> $stable(rdata_o));

endmodule

bind bcd_calendar_rtc rtc_checks u_rtc_checks (
  .clk_i   (clk_i),
  .rst_ni  (rst_n_q),
  .tick_i  (tick_i),
  .sel_i   (sel_i),
  .we_i    (we_i),
  .time_q  (time_q),
  .snap_q  (snap_q),
  .stop_q  (stop_q),
  .ctl_q   (ctl_q),
  .rdata_o (rdata_o)
);

// File: tb/test_bcd_calendar_rtc.sv
module test_bcd_calendar_rtc;

  localparam int AW = 13;
  localparam logic [AW-1:0] A_CTL = 13'h1FF8, A_SEC = 13'h1FF9, A_MIN = 13'h1FFA,
    A_HR = 13'h1FFB, A_DOW = 13'h1FFC, A_DATE = 13'h1FFD, A_MON = 13'h1FFE, A_YR = 13'h1FFF;

  logic clk, rst_n, tick, sel, we;
  logic [AW-1:0] addr;
  logic [7:0] wdata, rdata;

  int n_vec, n_bad;
  bit done;

  bcd_calendar_rtc #(.ADDR_W(AW)) i_bcd_calendar_rtc (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .sel_i(sel), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    sel = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    sel = 1'b0;
    d = rdata;
  endtask

  task automatic rdchk(input string req, input logic [AW-1:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  function automatic logic [7:0] bcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic int mdays(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int y, m, d, w;
    logic [7:0] tmp;
    n_vec = 0; n_bad = 0; done = 1'b0;
    tick = 0; sel = 0; we = 0; addr = '0; wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 reset values, R1 register order
    rdchk("R2 ctl", A_CTL, 8'h00);
    rdchk("R2 sec", A_SEC, 8'h00);
    rdchk("R2 min", A_MIN, 8'h00);
    rdchk("R2 hour", A_HR, 8'h00);
    rdchk("R2 dow", A_DOW, 8'h01);
    rdchk("R2 date", A_DATE, 8'h01);
    rdchk("R2 month", A_MON, 8'h01);
    rdchk("R2 year", A_YR, 8'h00);

    // R3 every second across the first hour and a bit
    for (int k = 1; k <= 3661; k++) begin
      pulse(1);
      rdchk("R3 sec", A_SEC, bcd(k % 60));
      rdchk("R3 min", A_MIN, bcd((k / 60) % 60));
      rdchk("R3 hour", A_HR, bcd(k / 3600));
    end

    // R4/R5 day-by-day walk from 98-01-01 to 02-12-31
    y = 98; m = 1; d = 1; w = 1;
    wr(A_YR, bcd(y)); wr(A_MON, bcd(m)); wr(A_DATE, bcd(d)); wr(A_DOW, 8'(w));
    for (int i = 0; i < 1826; i++) begin
      wr(A_SEC, 8'h59); wr(A_MIN, 8'h59); wr(A_HR, 8'h23);
      pulse(1);
      w = (w == 7) ? 1 : w + 1;
      if (d >= mdays(m, y)) begin
        d = 1;
        if (m == 12) begin
          m = 1;
          y = (y + 1) % 100;
        end else m = m + 1;
      end else d = d + 1;
      rdchk("R3 midnight sec", A_SEC, 8'h00);
      rdchk("R3 midnight min", A_MIN, 8'h00);
      rdchk("R3 midnight hour", A_HR, 8'h00);
      rdchk("R4 date", A_DATE, bcd(d));
      rdchk("R4 month", A_MON, bcd(m));
      rdchk("R4 year", A_YR, bcd(y));
      rdchk("R5 dow", A_DOW, 8'(w));
    end

    // R4 leap with tens digit: 12 is leap, 10 is not
    wr(A_YR, 8'h12); wr(A_MON, 8'h02); wr(A_DATE, 8'h28);
    wr(A_SEC, 8'h59); wr(A_MIN, 8'h59); wr(A_HR, 8'h23);
    pulse(1);
    rdchk("R4 leap12 date", A_DATE, 8'h29);
    rdchk("R4 leap12 month", A_MON, 8'h02);
    wr(A_YR, 8'h10); wr(A_DATE, 8'h28);
    wr(A_SEC, 8'h59); wr(A_MIN, 8'h59); wr(A_HR, 8'h23);
    pulse(1);
    rdchk("R4 year10 date", A_DATE, 8'h01);
    rdchk("R4 year10 month", A_MON, 8'h03);

    // R6 stop bit
    wr(A_SEC, 8'h90);
    pulse(4);
    rdchk("R6 stopped sec", A_SEC, 8'h90);
    wr(A_SEC, 8'h10);
    pulse(1);
    rdchk("R6 running sec", A_SEC, 8'h11);

    // R7 hold bit
    wr(A_CTL, 8'h80);
    rdchk("R7 ctl", A_CTL, 8'h80);
    wr(A_SEC, 8'h30);
    pulse(3);
    rdchk("R7 held sec", A_SEC, 8'h30);
    wr(A_CTL, 8'h00);
    pulse(1);
    rdchk("R7 resumed sec", A_SEC, 8'h31);

    // R8 freeze bit
    wr(A_SEC, 8'h00); wr(A_MIN, 8'h15);
    wr(A_CTL, 8'h40);
    pulse(5);
    rdchk("R8 frozen sec", A_SEC, 8'h00);
    rdchk("R8 frozen min", A_MIN, 8'h15);
    wr(A_CTL, 8'h00);
    rdchk("R8 live sec", A_SEC, 8'h05);

    // R1 outside the window
    wr(13'h0FF9, 8'h45);
    rdchk("R1 alias read", 13'h0FF9, 8'h00);
    rdchk("R1 sec untouched", A_SEC, 8'h05);

    // R9 unused bits
    wr(A_MIN, 8'hFF);  rdchk("R9 min mask", A_MIN, 8'h7F);
    wr(A_HR, 8'hFF);   rdchk("R9 hour mask", A_HR, 8'h3F);
    wr(A_DOW, 8'hFF);  rdchk("R9 dow mask", A_DOW, 8'h47);
    wr(A_DATE, 8'hFF); rdchk("R9 date mask", A_DATE, 8'h3F);
    wr(A_MON, 8'hFF);  rdchk("R9 month mask", A_MON, 8'h1F);
    wr(A_YR, 8'hFF);   rdchk("R9 year", A_YR, 8'hFF);
    wr(A_CTL, 8'h3F);  rdchk("R9 ctl trim", A_CTL, 8'h3F);
    wr(A_CTL, 8'h00);

    // R10 read data holds without a read strobe
    rd(A_YR, tmp);
    chk("R10 read", tmp, 8'hFF);
    wr(A_YR, 8'h12);
    pulse(2);
    @(negedge clk);
    chk("R10 hold", rdata, 8'hFF);
    rdchk("R10 new read", A_YR, 8'h12);

    finish_run();
  end

endmodule